// File: doc/BRIEF.md
# PLL Control Register Bank

This block is the byte-wide register file that software uses to program a clock-generation PLL. Six registers sit at consecutive byte addresses starting at a base address (default 0x36): control, bandwidth control, multiplier high, multiplier low, VCO range and reference divider. A plain synchronous bus reaches them through an address, write data, a write strobe, a read strobe and combinational read data. The programmed fields leave the block as plain outputs, and the analog loop uses them from there.

The block enforces the interlocks between control bits. Some bits are forced to a value, some turn read-only, and some read back as zero. The automatic-mode bit, the PLL-on bit and the base-clock-select bit decide which rule applies. A lock-status level and a one-cycle lock-change pulse arrive from the analog side. The block latches the pulse into a flag and raises an interrupt request when the flag and its enable are both set. The bus is a register-access port with no back-pressure. Every strobe completes in the cycle in which it is asserted, so the block has no valid/ready handshake.

Top module: `pll_regbank`

## Requirements
- R1: After reset, reads return control 0x20 (PLL on set), bandwidth 0x00, multiplier high 0x00, multiplier low 0x40, VCO range 0x40 and reference divider 0x01.
- R2: The six registers decode at base+0 to base+5 in the order control, bandwidth, multiplier high, multiplier low, VCO range, reference divider. A read of any other address returns 0x00, and a write to any other address changes nothing. Read data is 0x00 whenever the read strobe is low.
- R3: While automatic mode (bandwidth bit 7) is 0, the interrupt enable (control bit 7) is held at 0 and ignores writes. In that state the flag (control bit 6) and lock (bandwidth bit 6) read as 0.
- R4: The acquisition bit (bandwidth bit 5) takes written values only while automatic mode is 0. While automatic mode is 1 it is read-only.
- R5: While PLL on (control bit 5) is 0, or while the VCO range value is 0, base-clock select (control bit 4) stays 0 and ignores writes. A single control write that clears PLL on also leaves base-clock select at 0.
- R6: While PLL on is 1, writes to the multiplier high, multiplier low, VCO range and reference divider registers are ignored.
- R7: While base-clock select is 1, PLL on stays 1 and ignores writes.
- R8: The flag is set in the cycle after a lock-change pulse while automatic mode is 1. It is cleared by a read of the control register. A bus write never sets it. When a pulse and a control read fall in the same cycle, the read returns the old flag and the flag ends up set.
- R9: The interrupt request is high exactly while both the flag and the interrupt enable are 1.
- R10: The multiplier is 12 bits wide, with bits 11:8 in multiplier-high bits 3:0 and the upper bits reading 0. The reference divider occupies bits 3:0, and its upper bits read 0. The prescaler (control bits 3:2) and the VCO power range (control bits 1:0) are read/write. Each field appears on its output port in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (a control read clears the flag) |
| bus_rdata | output | 8 | Combinational read data |
| lock_in | input | 1 | Lock status level from the PLL |
| lock_evt | input | 1 | One-cycle lock-change pulse |
| irq | output | 1 | Interrupt request |
| auto_mode | output | 1 | Automatic bandwidth mode |
| acq_mode | output | 1 | Acquisition mode bit |
| pll_on | output | 1 | PLL enable |
| clk_sel | output | 1 | Base-clock select |
| presc | output | 2 | Prescaler field |
| vco_pwr | output | 2 | VCO power range field |
| mult | output | 12 | Multiplier value |
| vco_range | output | 8 | VCO range value |
| ref_div | output | 4 | Reference divider value |

## Verification
The hardest state to reach from the ports is base-clock select set. It requires PLL on and a non-zero VCO range at the same time, but the VCO range register accepts writes only while PLL on is 0. The stimulus therefore switches the PLL off, checks that base-clock select refuses to set while the range is zero, programs a non-zero range, then turns the PLL on and sets base-clock select. With base-clock select set, the bench checks that PLL on refuses to clear. The flag is driven with a lock pulse in the same cycle as a control read, so the set-over-clear priority is exercised.

// File: rtl/pll_regbank_pkg.sv
package pll_regbank_pkg;
  localparam int DW     = 8;
  localparam int NREGS  = 6;

  typedef enum logic [2:0] {
    RI_CTRL = 3'd0,
    RI_BW   = 3'd1,
    RI_MHI  = 3'd2,
    RI_MLO  = 3'd3,
    RI_VRS  = 3'd4,
    RI_RDS  = 3'd5
  } reg_idx_e;

  // control register bit positions
  localparam int CB_IE   = 7;
  localparam int CB_FLAG = 6;
  localparam int CB_ON   = 5;
  localparam int CB_BCS  = 4;
  // bandwidth register bit positions
  localparam int BB_AUTO = 7;
  localparam int BB_LOCK = 6;
  localparam int BB_ACQ  = 5;

  typedef struct packed {
    logic       ie;
    logic       flag;
    logic       on;
    logic       bcs;
    logic [1:0] pre;
    logic [1:0] vpr;
  } ctrl_t;
endpackage

// File: rtl/pll_addr_dec.sv
module pll_addr_dec
  import pll_regbank_pkg::*;
#(
  parameter logic [DW-1:0] BASE_ADDR = 8'h36
) (
  input  logic [DW-1:0]    addr,
  output logic [NREGS-1:0] sel
);
  for (genvar i = 0; i < NREGS; i++) begin : g_sel
    localparam logic [DW-1:0] MATCH = BASE_ADDR + DW'(i);
    assign sel[i] = (addr == MATCH);
  end
endmodule

// File: rtl/pll_ctrl_regs.sv
module pll_ctrl_regs
  import pll_regbank_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ctrl,
  input  logic          wr_bw,
  input  logic          rd_ctrl,
  input  logic [DW-1:0] wdata,
  input  logic          lock_evt,
  input  logic          vrs_nz,
  output ctrl_t         ctrl,
  output logic          auto_mode,
  output logic          acq
);
  ctrl_t ctrl_q, ctrl_d;
  logic  auto_q, auto_d, acq_q, acq_d;

  always_comb begin
    auto_d = wr_bw ? wdata[BB_AUTO] : auto_q;
    acq_d  = (wr_bw && !auto_q) ? wdata[BB_ACQ] : acq_q;

    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.pre = wdata[3:2];
      ctrl_d.vpr = wdata[1:0];
    end
    // enable: writable only in automatic mode, dropped when mode leaves
    ctrl_d.ie = auto_d & (wr_ctrl ? (wdata[CB_IE] & auto_q) : ctrl_q.ie);
    // flag: pulse sets (priority), control read clears, bus write never sets
    if (auto_q && lock_evt)  ctrl_d.flag = 1'b1;
    else if (rd_ctrl)        ctrl_d.flag = 1'b0;
    ctrl_d.flag = ctrl_d.flag & auto_d;
    // PLL on pinned while base clock selected
    ctrl_d.on  = ctrl_q.bcs ? 1'b1 : (wr_ctrl ? wdata[CB_ON] : ctrl_q.on);
    // base clock select needs PLL on and a non-zero range
    ctrl_d.bcs = ctrl_d.on & vrs_nz & (wr_ctrl ? wdata[CB_BCS] : ctrl_q.bcs);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '{ie: 1'b0, flag: 1'b0, on: 1'b1, bcs: 1'b0, pre: 2'b00, vpr: 2'b00};
      auto_q <= 1'b0;
      acq_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      auto_q <= auto_d;
      acq_q  <= acq_d;
    end
  end

  assign ctrl      = ctrl_q;
  assign auto_mode = auto_q;
  assign acq       = acq_q;
endmodule

// File: rtl/pll_prog_regs.sv
module pll_prog_regs #(
  parameter int MULT_W    = 12,
  parameter int VRS_W     = 8,
  parameter int RDS_W     = 4,
  parameter logic [MULT_W-1:0] MULT_RST = 12'h040,
  parameter logic [VRS_W-1:0]  VRS_RST  = 8'h40,
  parameter logic [RDS_W-1:0]  RDS_RST  = 4'h1,
  localparam int HI_W = MULT_W - 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              locked,
  input  logic              wr_mhi,
  input  logic              wr_mlo,
  input  logic              wr_vrs,
  input  logic              wr_rds,
  input  logic [HI_W-1:0]   wd_hi,
  input  logic [7:0]        wd_byte,
  input  logic [RDS_W-1:0]  wd_rds,
  output logic [MULT_W-1:0] mult,
  output logic [VRS_W-1:0]  vrs,
  output logic [RDS_W-1:0]  rds
);
  logic [MULT_W-1:0] mult_q;
  logic [VRS_W-1:0]  vrs_q;
  logic [RDS_W-1:0]  rds_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mult_q <= MULT_RST;
      vrs_q  <= VRS_RST;
      rds_q  <= RDS_RST;
    end else if (!locked) begin
      if (wr_mhi) mult_q[MULT_W-1:8] <= wd_hi;
      if (wr_mlo) mult_q[7:0]        <= wd_byte;
      if (wr_vrs) vrs_q              <= wd_byte[VRS_W-1:0];
      if (wr_rds) rds_q              <= wd_rds;
    end
  end

  assign mult = mult_q;
  assign vrs  = vrs_q;
  assign rds  = rds_q;
endmodule

// File: rtl/pll_read_mux.sv
module pll_read_mux
  import pll_regbank_pkg::*;
#(
  parameter int MULT_W = 12,
  parameter int VRS_W  = 8,
  parameter int RDS_W  = 4
) (
  input  logic [NREGS-1:0]  sel,
  input  logic              re,
  input  ctrl_t             ctrl,
  input  logic              auto_mode,
  input  logic              acq,
  input  logic              lock_in,
  input  logic [MULT_W-1:0] mult,
  input  logic [VRS_W-1:0]  vrs,
  input  logic [RDS_W-1:0]  rds,
  output logic [DW-1:0]     rdata
);
  logic [DW-1:0] img [NREGS];

  always_comb begin
    img[RI_CTRL] = ctrl;
    img[RI_BW]   = {auto_mode, lock_in & auto_mode, acq, 5'b0};
    img[RI_MHI]  = DW'(mult[MULT_W-1:8]);
    img[RI_MLO]  = mult[7:0];
    img[RI_VRS]  = DW'(vrs);
    img[RI_RDS]  = DW'(rds);
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREGS; i++)
      if (re && sel[i]) rdata = rdata | img[i];
  end
endmodule

// File: rtl/pll_regbank.sv
module pll_regbank
  import pll_regbank_pkg::*;
#(
  parameter logic [7:0] BASE_ADDR = 8'h36,
  parameter int MULT_W = 12,
  parameter int VRS_W  = 8,
  parameter int RDS_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [7:0]        bus_rdata,
  input  logic              lock_in,
  input  logic              lock_evt,
  output logic              irq,
  output logic              auto_mode,
  output logic              acq_mode,
  output logic              pll_on,
  output logic              clk_sel,
  output logic [1:0]        presc,
  output logic [1:0]        vco_pwr,
  output logic [MULT_W-1:0] mult,
  output logic [VRS_W-1:0]  vco_range,
  output logic [RDS_W-1:0]  ref_div
);
  localparam int HI_W = MULT_W - 8;

  logic [NREGS-1:0] sel, wr;
  ctrl_t            ctrl;
  logic             ie_w, flag_w;

  pll_addr_dec #(.BASE_ADDR(BASE_ADDR)) u_dec (.addr(bus_addr), .sel(sel));
  assign wr = sel & {NREGS{bus_we}};

  pll_ctrl_regs u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_ctrl(wr[RI_CTRL]), .wr_bw(wr[RI_BW]),
    .rd_ctrl(bus_re && sel[RI_CTRL]),
    .wdata(bus_wdata), .lock_evt(lock_evt),
    .vrs_nz(|vco_range),
    .ctrl(ctrl), .auto_mode(auto_mode), .acq(acq_mode)
  );

  pll_prog_regs #(.MULT_W(MULT_W), .VRS_W(VRS_W), .RDS_W(RDS_W)) u_prog (
    .clk(clk), .rst_n(rst_n), .locked(pll_on),
    .wr_mhi(wr[RI_MHI]), .wr_mlo(wr[RI_MLO]),
    .wr_vrs(wr[RI_VRS]), .wr_rds(wr[RI_RDS]),
    .wd_hi(bus_wdata[HI_W-1:0]), .wd_byte(bus_wdata),
    .wd_rds(bus_wdata[RDS_W-1:0]),
    .mult(mult), .vrs(vco_range), .rds(ref_div)
  );

  pll_read_mux #(.MULT_W(MULT_W), .VRS_W(VRS_W), .RDS_W(RDS_W)) u_rmux (
    .sel(sel), .re(bus_re), .ctrl(ctrl), .auto_mode(auto_mode),
    .acq(acq_mode), .lock_in(lock_in), .mult(mult), .vrs(vco_range),
    .rds(ref_div), .rdata(bus_rdata)
  );

  assign ie_w    = ctrl.ie;
  assign flag_w  = ctrl.flag;
  assign pll_on  = ctrl.on;
  assign clk_sel = ctrl.bcs;
  assign presc   = ctrl.pre;
  assign vco_pwr = ctrl.vpr;
  assign irq     = ie_w & flag_w;
endmodule

// File: rtl/pll_regbank_chk.sv
module pll_regbank_chk #(
  parameter int MULT_W = 12,
  parameter int VRS_W  = 8,
  parameter int RDS_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              auto_mode,
  input logic              ie,
  input logic              flag,
  input logic              irq,
  input logic              lock_evt,
  input logic              pll_on,
  input logic              clk_sel,
  input logic [MULT_W-1:0] mult,
  input logic [VRS_W-1:0]  vco_range,
  input logic [RDS_W-1:0]  ref_div
);
  assert_ie_off_manual_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_mode |-> (!ie && !flag && !irq));

  assert_bcs_needs_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pll_on || vco_range == '0) |-> !clk_sel);

  assert_prog_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pll_on |=> ($stable(mult) && $stable(vco_range) && $stable(ref_div)));

  assert_on_pinned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sel |=> pll_on);

  assert_flag_from_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(lock_evt));

  assert_flag_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_mode && lock_evt) |=> (flag || !auto_mode));
endmodule

bind pll_regbank pll_regbank_chk #(.MULT_W(MULT_W), .VRS_W(VRS_W), .RDS_W(RDS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode), .ie(ie_w), .flag(flag_w),
  .irq(irq), .lock_evt(lock_evt), .pll_on(pll_on), .clk_sel(clk_sel),
  .mult(mult), .vco_range(vco_range), .ref_div(ref_div)
);

// File: tb/pll_regbank_tb.sv
module pll_regbank_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0, bus_wdata = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [7:0]  bus_rdata;
  logic        lock_in = 1'b0, lock_evt = 1'b0;
  logic        irq, auto_mode, acq_mode, pll_on, clk_sel;
  logic [1:0]  presc, vco_pwr;
  logic [11:0] mult;
  logic [7:0]  vco_range;
  logic [3:0]  ref_div;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  localparam logic [7:0] A_CTRL = 8'h36, A_BW = 8'h37, A_MHI = 8'h38,
                         A_MLO = 8'h39, A_VRS = 8'h3A, A_RDS = 8'h3B;

  always #2 clk = ~clk;

  pll_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .lock_in(lock_in), .lock_evt(lock_evt), .irq(irq), .auto_mode(auto_mode),
    .acq_mode(acq_mode), .pll_on(pll_on), .clk_sel(clk_sel), .presc(presc),
    .vco_pwr(vco_pwr), .mult(mult), .vco_range(vco_range), .ref_div(ref_div)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [7:0] exp, bit evt = 1'b0);
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1; lock_evt = evt;
    #1 check(req, bus_rdata, exp);
    @(posedge clk); #1;
    bus_re = 1'b0; lock_evt = 1'b0;
  endtask

  task automatic pulse_evt();
    @(negedge clk); lock_evt = 1'b1;
    @(posedge clk); #1 lock_evt = 1'b0;
  endtask

  task automatic t_reset_R1();
    rd_chk("R1", A_CTRL, 8'h20);
    rd_chk("R1", A_BW,   8'h00);
    rd_chk("R1", A_MHI,  8'h00);
    rd_chk("R1", A_MLO,  8'h40);
    rd_chk("R1", A_VRS,  8'h40);
    rd_chk("R1", A_RDS,  8'h01);
    check("R1", {pll_on, clk_sel, irq}, 3'b100);
  endtask

  task automatic t_decode_R2();
    rd_chk("R2", 8'h35, 8'h00);
    rd_chk("R2", 8'h3C, 8'h00);
    wr(8'h3C, 8'hFF);
    wr(8'h35, 8'hFF);
    rd_chk("R2", A_CTRL, 8'h20);
    rd_chk("R2", A_BW, 8'h00);
    @(negedge clk); bus_addr = A_MLO; #1 check("R2", bus_rdata, 8'h00);
  endtask

  task automatic t_manual_R3_R4();
    lock_in = 1'b1;
    wr(A_CTRL, 8'hA0);
    rd_chk("R3", A_CTRL, 8'h20);
    pulse_evt();
    rd_chk("R3", A_CTRL, 8'h20);
    rd_chk("R3", A_BW, 8'h00);
    check("R3", irq, 1'b0);
    wr(A_BW, 8'h20);
    rd_chk("R4", A_BW, 8'h20);
    check("R4", acq_mode, 1'b1);
  endtask

  task automatic t_prog_lock_R6_R10();
    wr(A_MLO, 8'h55);
    wr(A_VRS, 8'h11);
    wr(A_RDS, 8'h09);
    rd_chk("R6", A_MLO, 8'h40);
    check("R6", {mult, vco_range, ref_div}, {12'h040, 8'h40, 4'h1});
    wr(A_CTRL, 8'h00);
    check("R10", pll_on, 1'b0);
    wr(A_MHI, 8'hFA);
    wr(A_MLO, 8'h12);
    wr(A_RDS, 8'hF7);
    wr(A_VRS, 8'h00);
    rd_chk("R10", A_MHI, 8'h0A);
    rd_chk("R10", A_RDS, 8'h07);
    check("R10", {mult, ref_div}, {12'hA12, 4'h7});
  endtask

  task automatic t_bcs_R5_R7();
    wr(A_CTRL, 8'h10);
    rd_chk("R5", A_CTRL, 8'h00);
    wr(A_CTRL, 8'h30);
    rd_chk("R5", A_CTRL, 8'h20);
    check("R5", clk_sel, 1'b0);
    wr(A_CTRL, 8'h00);
    wr(A_VRS, 8'h80);
    rd_chk("R5", A_VRS, 8'h80);
    wr(A_CTRL, 8'h3D);
    rd_chk("R10", A_CTRL, 8'h3D);
    check("R10", {clk_sel, presc, vco_pwr}, {1'b1, 2'b11, 2'b01});
    wr(A_CTRL, 8'h0D);
    rd_chk("R7", A_CTRL, 8'h2D);
    check("R7", pll_on, 1'b1);
    wr(A_CTRL, 8'h0D);
    rd_chk("R7", A_CTRL, 8'h0D);
    wr(A_CTRL, 8'h20);
  endtask

  task automatic t_auto_R4_R8_R9();
    wr(A_BW, 8'h80);
    rd_chk("R4", A_BW, 8'hC0);
    wr(A_BW, 8'hA0);
    rd_chk("R4", A_BW, 8'hC0);
    check("R4", acq_mode, 1'b0);
    wr(A_CTRL, 8'hE0);
    rd_chk("R8", A_CTRL, 8'hA0);
    check("R9", irq, 1'b0);
    pulse_evt();
    check("R9", irq, 1'b1);
    rd_chk("R8", A_CTRL, 8'hE0);
    rd_chk("R8", A_CTRL, 8'hA0);
    check("R9", irq, 1'b0);
    rd_chk("R8", A_CTRL, 8'hA0, 1'b1);
    rd_chk("R8", A_CTRL, 8'hE0);
    pulse_evt();
    wr(A_CTRL, 8'h20);
    check("R9", irq, 1'b0);
    rd_chk("R8", A_CTRL, 8'h60);
    pulse_evt();
    wr(A_BW, 8'h00);
    rd_chk("R3", A_CTRL, 8'h20);
    check("R3", irq, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset_R1();
    t_decode_R2();
    t_manual_R3_R4();
    t_prog_lock_R6_R10();
    t_bcs_R5_R7();
    t_auto_R4_R8_R9();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule